// File: doc/BRIEF.md
# Successive-Approximation ADC Control and Status Sequencer

This block is the register front end and phase sequencer of a successive-approximation converter. Software reaches four byte-wide locations through a plain write strobe with a combinational read: a control register, a port-configuration register, the result register and an interrupt-flag register. From the control register the block chooses the input channel, the bit clock and module enable. It holds the external sample switch closed while the module acquires. When a start is requested, it opens the switch and fires a one-cycle start pulse to a separate conversion engine. The engine reports completion with a done strobe and its data word.

The sequencer has six states. ST_OFF is the module disabled. ST_ACQ is acquiring with the switch closed. ST_DELAY is a fixed start delay used only with the internal RC bit clock. ST_CONV is converting. ST_HOLD is the forced post-conversion wait. ST_PDOWN is powered down while enable stays set.

The transitions are as follows:
- Enable moves ST_OFF to ST_ACQ.
- A pending start moves ST_ACQ to ST_CONV, or to ST_DELAY when the RC clock is selected. ST_DELAY moves to ST_CONV after its delay.
- A completion or a software abort moves ST_CONV (or ST_DELAY) to ST_HOLD. Two bit periods later ST_HOLD returns to ST_ACQ on its own.
- A sleep request moves ST_ACQ to ST_PDOWN. It also moves ST_CONV to ST_PDOWN when the clock is not RC. With the RC clock and the interrupt disabled, a completion during sleep moves ST_CONV to ST_PDOWN. Dropping sleep returns ST_PDOWN to ST_ACQ.
- Clearing enable moves any state to ST_OFF.

An external event trigger can request a start in place of software.

Top module: `sar_ctl_seq`

## Requirements
- R1: After reset the control, port-configuration and flag registers read zero, and pwr_on and sample_en are low.
- R2: The register addresses are 0 = control, 1 = port configuration, 2 = result, 3 = flag (bit 0). The control fields are clock select [7:6] (3 = internal RC), channel [5:3], start/busy [2], a spare bit [1] and enable [0]. The port-configuration register stores only bits 2:0, and bits 7:3 read zero. chan_sel and port_cfg follow the stored fields. The start bit cannot be set while enable is 0, including in the same write that sets enable.
- R3: When the engine reports done during a conversion, the result register takes eng_data, the start bit clears and the flag sets, all on the same clock edge.
- R4: If software clears the start bit during a conversion, the conversion aborts. The result register keeps its value and the flag is not set, and a later done strobe outside a conversion changes neither.
- R5: After a completion or an abort, sample_en stays low for exactly two bit periods. The block then returns to acquiring on the selected channel with no software action.
- R6: The event trigger sets the start bit only while enable is 1. While enable is 0 it is ignored: the start bit stays 0 and no start pulse appears.
- R7: Reset aborts any conversion and turns the module off, and it leaves the result register unchanged.
- R8: With clock select 3, the start pulse comes INSTR_CLKS cycles later than with the other selections. A sleep request does not abort such a conversion.
- R9: With clock select 0 to 2, a sleep request during a conversion aborts it and powers the module down (pwr_on low, start bit cleared). Enable stays 1, and the result and flag stay unchanged.
- R10: When a conversion completes while sleep is requested, wake_req pulses if irq_en is 1. If irq_en is 0, the module powers down instead.
- R11: The flag is cleared only by writing 0 to bit 0 of address 3. Writing 1 there changes nothing.
- R12: A software write to the result register holds until the next completed conversion.
- R13: Clock selections 0, 1 and 2 give a bit period of 2, 8 and 32 clocks. Selection 3 uses rc_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| evt_trig | input | 1 | External start trigger |
| sleep_req | input | 1 | Sleep request level |
| irq_en | input | 1 | Interrupt enable, selects wake or power-down |
| rc_tick | input | 1 | Bit tick from the internal RC oscillator, already synchronised |
| eng_done | input | 1 | Conversion-engine done strobe |
| eng_data | input | RES_W | Conversion-engine result |
| chan_sel | output | 3 | Selected analog channel |
| port_cfg | output | PCFG_W | Pin configuration code |
| sample_en | output | 1 | Sample switch closed (acquiring) |
| conv_start | output | 1 | One-cycle start pulse to the engine |
| bit_tick | output | 1 | Bit-period tick to the engine |
| pwr_on | output | 1 | Module powered |
| irq_flag | output | 1 | Interrupt flag |
| wake_req | output | 1 | Wake-up request pulse |

## Verification
The hardest situation to reach is a completion that lands while sleep is requested under the RC clock. It needs the RC start delay to have passed, sleep raised after the start pulse, and the done strobe timed against rc_tick. The bench builds this from its own engine model: it waits for conv_start, raises sleep_req, counts bit ticks and then drives eng_done. It runs this once with irq_en high and once with it low. Abort timing is reached the same way. The bench clears the start bit, or raises sleep under a divided clock, in the cycle after the start pulse, and then counts the cycles until sample_en rises again.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ACQ,
        ST_DELAY,
        ST_CONV,
        ST_HOLD,
        ST_PDOWN
    } seq_state_t;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic [2:0] chan;
        logic       go;
        logic       spare;
        logic       en;
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PCFG = 2'd1;
    localparam logic [1:0] ADDR_RES  = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    localparam logic [1:0] CLK_RC = 2'b11;

endpackage

// File: rtl/sar_ctl_regs.sv
module sar_ctl_regs
    import sar_ctl_pkg::*;
#(
    parameter int RES_W  = 8,
    parameter int PCFG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              trig,
    input  logic              go_clr,
    input  logic              done_load,
    input  logic [RES_W-1:0]  done_data,
    output ctrl_t             ctrl_o,
    output logic [PCFG_W-1:0] pcfg_o,
    output logic              flag_o
);

    localparam int PCFG_PAD = 8 - PCFG_W;
    localparam int RES_PAD  = 8 - RES_W;

    ctrl_t             ctrl_q;
    logic [PCFG_W-1:0] pcfg_q;
    logic [RES_W-1:0]  res_q;
    logic              flag_q;

    logic ctrl_wr, pcfg_wr, res_wr, flag_wr;

    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
        pcfg_wr = bus_wr && (bus_addr == ADDR_PCFG);
        res_wr  = bus_wr && (bus_addr == ADDR_RES);
        flag_wr = bus_wr && (bus_addr == ADDR_FLAG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pcfg_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.clk_sel <= bus_wdata[7:6];
                ctrl_q.chan    <= bus_wdata[5:3];
                ctrl_q.spare   <= bus_wdata[1];
                ctrl_q.en      <= bus_wdata[0];
            end
            if (go_clr || !ctrl_q.en) begin
                ctrl_q.go <= 1'b0;
            end else if (trig) begin
                ctrl_q.go <= 1'b1;
            end else if (ctrl_wr) begin
                ctrl_q.go <= bus_wdata[2];
            end
            if (pcfg_wr) begin
                pcfg_q <= bus_wdata[PCFG_W-1:0];
            end
            if (done_load) begin
                flag_q <= 1'b1;
            end else if (flag_wr && !bus_wdata[0]) begin
                flag_q <= 1'b0;
            end
        end
    end

    // the result register is deliberately left out of reset
    always_ff @(posedge clk) begin
        if (done_load) begin
            res_q <= done_data;
        end else if (res_wr) begin
            res_q <= bus_wdata[RES_W-1:0];
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_PCFG: bus_rdata = {{PCFG_PAD{1'b0}}, pcfg_q};
            ADDR_RES:  bus_rdata = {{RES_PAD{1'b0}}, res_q};
            default:   bus_rdata = {7'd0, flag_q};
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign pcfg_o = pcfg_q;
    assign flag_o = flag_q;

    // R3
    result_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_load |=> (res_q == $past(done_data)) && flag_q && !ctrl_q.go);

    // R4
    result_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_load && !res_wr) |=> $stable(res_q));

    // R6
    go_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !ctrl_wr) |=> !ctrl_q.go);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(flag_wr && !bus_wdata[0])) |=> flag_q);

endmodule

// File: rtl/sar_bit_clk.sv
module sar_bit_clk
    import sar_ctl_pkg::*;
#(
    parameter int DIV_A = 2,
    parameter int DIV_B = 8,
    parameter int DIV_C = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] sel,
    input  logic       rc_tick,
    output logic       tick
);

    localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int MAX_D  = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
    localparam int CW     = (MAX_D > 2) ? $clog2(MAX_D) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          at_lim;

    always_comb begin
        unique case (sel)
            2'd0:    lim = CW'(DIV_A - 1);
            2'd1:    lim = CW'(DIV_B - 1);
            2'd2:    lim = CW'(DIV_C - 1);
            default: lim = '0;
        endcase
        at_lim = (cnt_q >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clr || at_lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && ((sel == CLK_RC) ? rc_tick : at_lim);

    // R13
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != CLK_RC) |=> (!tick || sel == CLK_RC));

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_ctl_pkg::*;
#(
    parameter int INSTR_CLKS = 4,
    parameter int HOLD_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       go,
    input  logic [1:0] clk_sel,
    input  logic       sleep_req,
    input  logic       irq_en,
    input  logic       eng_done,
    input  logic       tick,
    output logic       sample_en,
    output logic       pwr_on,
    output logic       conv_start,
    output logic       div_clr,
    output logic       done_load,
    output logic       go_clr,
    output logic       wake_req
);

    localparam int DLY_W  = $clog2(INSTR_CLKS + 1);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

    seq_state_t        state_q, state_d;
    logic [DLY_W-1:0]  dly_q;
    logic [HOLD_W-1:0] hold_q;
    logic              start_q;
    logic              wake_q;
    logic              use_rc;
    logic              sleep_abort;

    assign use_rc = (clk_sel == CLK_RC);

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_ACQ;
                ST_ACQ: begin
                    if (sleep_req)   state_d = ST_PDOWN;
                    else if (go)     state_d = use_rc ? ST_DELAY : ST_CONV;
                end
                ST_DELAY: begin
                    if (!go)                                  state_d = ST_HOLD;
                    else if (dly_q == DLY_W'(INSTR_CLKS - 1)) state_d = ST_CONV;
                end
                ST_CONV: begin
                    if (!go)                    state_d = ST_HOLD;
                    else if (eng_done)          state_d = (sleep_req && use_rc && !irq_en) ? ST_PDOWN : ST_HOLD;
                    else if (sleep_req && !use_rc) state_d = ST_PDOWN;
                end
                ST_HOLD: begin
                    if (tick && hold_q == HOLD_W'(HOLD_TICKS - 1)) state_d = ST_ACQ;
                end
                ST_PDOWN: begin
                    if (!sleep_req) state_d = ST_ACQ;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register and phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            dly_q   <= '0;
            hold_q  <= '0;
            start_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= (state_d == ST_CONV) && (state_q != ST_CONV);
            wake_q  <= done_load && sleep_req && irq_en;
            if (state_q != ST_DELAY) dly_q <= '0;
            else                     dly_q <= dly_q + 1'b1;
            if (state_q != ST_HOLD)  hold_q <= '0;
            else if (tick)           hold_q <= hold_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sample_en   = (state_q == ST_ACQ);
        pwr_on      = !(state_q inside {ST_OFF, ST_PDOWN});
        done_load   = (state_q == ST_CONV) && en && go && eng_done;
        sleep_abort = (state_q == ST_CONV) && go && !eng_done && sleep_req && !use_rc;
        go_clr      = done_load || sleep_abort || (state_q == ST_OFF);
        div_clr     = (state_q != state_d);
        conv_start  = start_q;
        wake_req    = wake_q;
    end

    // R8
    rc_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && $past(state_q) == ST_ACQ) |-> $past(clk_sel) != CLK_RC);

    // R5
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !tick) |=> (state_q == ST_HOLD || state_q == ST_OFF));

    // R9
    sleep_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && en && go && sleep_req && !eng_done && !use_rc) |=> state_q == ST_PDOWN);

    // R10
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(sleep_req && irq_en && eng_done));

endmodule

// File: rtl/sar_ctl_seq.sv
module sar_ctl_seq
    import sar_ctl_pkg::*;
#(
    parameter int RES_W      = 8,
    parameter int PCFG_W     = 3,
    parameter int DIV_A      = 2,
    parameter int DIV_B      = 8,
    parameter int DIV_C      = 32,
    parameter int INSTR_CLKS = 4,
    parameter int HOLD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              evt_trig,
    input  logic              sleep_req,
    input  logic              irq_en,
    input  logic              rc_tick,
    input  logic              eng_done,
    input  logic [RES_W-1:0]  eng_data,
    output logic [2:0]        chan_sel,
    output logic [PCFG_W-1:0] port_cfg,
    output logic              sample_en,
    output logic              conv_start,
    output logic              bit_tick,
    output logic              pwr_on,
    output logic              irq_flag,
    output logic              wake_req
);

    ctrl_t ctrl;
    logic  go_clr, done_load, div_clr, tick;

    sar_ctl_regs #(
        .RES_W  (RES_W),
        .PCFG_W (PCFG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .trig      (evt_trig),
        .go_clr    (go_clr),
        .done_load (done_load),
        .done_data (eng_data),
        .ctrl_o    (ctrl),
        .pcfg_o    (port_cfg),
        .flag_o    (irq_flag)
    );

    sar_bit_clk #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B),
        .DIV_C (DIV_C)
    ) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pwr_on),
        .clr     (div_clr),
        .sel     (ctrl.clk_sel),
        .rc_tick (rc_tick),
        .tick    (tick)
    );

    sar_seq_fsm #(
        .INSTR_CLKS (INSTR_CLKS),
        .HOLD_TICKS (HOLD_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl.en),
        .go         (ctrl.go),
        .clk_sel    (ctrl.clk_sel),
        .sleep_req  (sleep_req),
        .irq_en     (irq_en),
        .eng_done   (eng_done),
        .tick       (tick),
        .sample_en  (sample_en),
        .pwr_on     (pwr_on),
        .conv_start (conv_start),
        .div_clr    (div_clr),
        .done_load  (done_load),
        .go_clr     (go_clr),
        .wake_req   (wake_req)
    );

    assign chan_sel = ctrl.chan;
    assign bit_tick = tick;

endmodule

// File: tb/sar_ctl_seq_bench.sv
module sar_ctl_seq_bench;

    localparam int INSTR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       evt_trig = 1'b0;
    logic       sleep_req = 1'b0;
    logic       irq_en = 1'b0;
    logic       rc_tick = 1'b0;
    logic       eng_done = 1'b0;
    logic [7:0] eng_data = '0;
    logic [2:0] chan_sel;
    logic [2:0] port_cfg;
    logic       sample_en, conv_start, bit_tick, pwr_on, irq_flag, wake_req;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (5) @(posedge clk);
            #1 rc_tick = 1'b1;
            @(posedge clk);
            #1 rc_tick = 1'b0;
        end
    end

    sar_ctl_seq #(.INSTR_CLKS(INSTR)) u_sar_ctl_seq (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_trig(evt_trig),
        .sleep_req(sleep_req), .irq_en(irq_en), .rc_tick(rc_tick),
        .eng_done(eng_done), .eng_data(eng_data), .chan_sel(chan_sel),
        .port_cfg(port_cfg), .sample_en(sample_en), .conv_start(conv_start),
        .bit_tick(bit_tick), .pwr_on(pwr_on), .irq_flag(irq_flag), .wake_req(wake_req)
    );

    // {clock select, channel, engine data}
    localparam logic [12:0] VEC [0:5] = '{
        {2'd0, 3'd0, 8'h00},
        {2'd1, 3'd3, 8'hA5},
        {2'd2, 3'd7, 8'hFF},
        {2'd0, 3'd5, 8'h3C},
        {2'd1, 3'd1, 8'h81},
        {2'd0, 3'd2, 8'h7E}
    };

    function automatic int divof(input int m);
        case (m)
            0:       return 2;
            1:       return 8;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // counts negedges from the current one (index 1) until conv_start is seen
    task automatic wait_start(output int n);
        n = 1;
        while (!conv_start && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    // engine model: waits some bit ticks, then reports done; returns just after the done edge
    task automatic finish(input logic [7:0] d, input int ticks);
        int k = 0;
        int guard = 0;
        while (k < ticks && guard < 1000) begin
            @(negedge clk);
            guard++;
            if (bit_tick) k++;
        end
        eng_done = 1'b1; eng_data = d;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic count_hold(output int n);
        n = 1;
        while (!sample_en && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int n;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, r); chk("R1 ctrl", r, 0);
        rd(2'd1, r); chk("R1 pcfg", r, 0);
        rd(2'd3, r); chk("R1 flag", r, 0);
        chk("R1 pwr_on", pwr_on, 0);
        chk("R1 sample_en", sample_en, 0);

        // R2 port configuration width
        wr(2'd1, 8'hFF);
        rd(2'd1, r); chk("R2 pcfg readback", r, 8'h07);
        chk("R2 port_cfg", port_cfg, 3'd7);
        wr(2'd1, 8'h05);
        chk("R2 port_cfg update", port_cfg, 3'd5);

        // R2 start bit refused in the enabling write
        wr(2'd0, 8'h05);
        rd(2'd0, r); chk("R2 go with enable", r[2], 0);
        wr(2'd0, 8'h00);
        idle(2);

        // table of conversions
        for (int i = 0; i < 6; i++) begin
            logic [1:0] m;
            logic [2:0] ch;
            logic [7:0] d;
            m = VEC[i][12:11]; ch = VEC[i][10:8]; d = VEC[i][7:0];
            wr(2'd0, {m, ch, 3'b001});
            idle(3);
            chk("R2 chan_sel", chan_sel, ch);
            chk("R5 acquiring", sample_en, 1);
            wr(2'd3, 8'h00);
            wr(2'd0, {m, ch, 3'b101});
            wait_start(n);
            chk("R3 start pulse", conv_start, 1);
            chk("R3 switch open", sample_en, 0);
            finish(d, 3);
            rd(2'd2, r); chk("R3 result", r, d);
            rd(2'd0, r); chk("R3 go cleared", r[2], 0);
            rd(2'd3, r); chk("R3 flag set", r, 1);
            count_hold(n);
            chk("R5 R13 hold length", n - 1, 2 * divof(m));
        end

        // R11 flag clear rules (flag is 1 here)
        wr(2'd3, 8'hFF);
        rd(2'd3, r); chk("R11 write one keeps", r, 1);
        wr(2'd3, 8'h00);
        rd(2'd3, r); chk("R11 write zero clears", r, 0);
        wr(2'd3, 8'h01);
        rd(2'd3, r); chk("R11 write one no set", r, 0);

        // R6 trigger ignored while disabled
        wr(2'd0, 8'h00);
        @(negedge clk); evt_trig = 1'b1;
        @(negedge clk); evt_trig = 1'b0;
        n = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (conv_start) n++;
        end
        rd(2'd0, r); chk("R6 go stays 0", r[2], 0);
        chk("R6 no start", n, 0);

        // R6 trigger starts when enabled, then R4 abort
        wr(2'd0, {2'd0, 3'd1, 3'b001});
        idle(3);
        @(negedge clk); evt_trig = 1'b1;
        @(negedge clk); evt_trig = 1'b0;
        wait_start(n);
        chk("R6 trigger start", conv_start, 1);
        wr(2'd0, {2'd0, 3'd1, 3'b001});
        count_hold(n);
        chk("R5 abort hold", n, 2 * 2 + 2);
        eng_done = 1'b1; eng_data = 8'h11;
        @(negedge clk); eng_done = 1'b0;
        rd(2'd2, r); chk("R4 result kept", r, 8'h7E);
        rd(2'd3, r); chk("R4 flag not set", r, 0);

        // R12 software result write
        wr(2'd2, 8'h3C);
        eng_done = 1'b1; eng_data = 8'h22;
        @(negedge clk); eng_done = 1'b0;
        idle(2);
        rd(2'd2, r); chk("R12 written value held", r, 8'h3C);

        // R8 RC start delay, R10 wake with interrupt enabled
        wr(2'd0, {2'd3, 3'd0, 3'b001});
        idle(3);
        wr(2'd0, {2'd3, 3'd0, 3'b101});
        wait_start(n);
        chk("R8 rc delay", n, INSTR + 2);
        irq_en = 1'b1; sleep_req = 1'b1;
        idle(2);
        rd(2'd0, r); chk("R8 sleep no abort", r[2], 1);
        chk("R8 still powered", pwr_on, 1);
        finish(8'h66, 3);
        chk("R10 wake pulse", wake_req, 1);
        rd(2'd2, r); chk("R3 rc result", r, 8'h66);
        idle(40);
        chk("R10 sleeps after hold", pwr_on, 0);
        rd(2'd0, r); chk("R9 enable kept", r[0], 1);
        sleep_req = 1'b0; irq_en = 1'b0;
        idle(3);
        chk("R5 reacquire after wake", sample_en, 1);

        // R10 completion in sleep with interrupt disabled
        wr(2'd3, 8'h00);
        wr(2'd0, {2'd3, 3'd0, 3'b101});
        wait_start(n);
        sleep_req = 1'b1;
        finish(8'h99, 2);
        chk("R10 no wake", wake_req, 0);
        chk("R10 powered down", pwr_on, 0);
        rd(2'd2, r); chk("R10 result", r, 8'h99);
        rd(2'd3, r); chk("R10 flag", r, 1);
        sleep_req = 1'b0;
        idle(3);

        // R9 sleep abort with divided clock
        wr(2'd3, 8'h00);
        wr(2'd0, {2'd1, 3'd2, 3'b001});
        idle(3);
        wr(2'd0, {2'd1, 3'd2, 3'b101});
        wait_start(n);
        sleep_req = 1'b1;
        @(negedge clk);
        chk("R9 powered down", pwr_on, 0);
        rd(2'd0, r); chk("R9 go cleared", r[2], 0);
        chk("R9 enable kept", r[0], 1);
        rd(2'd2, r); chk("R9 result kept", r, 8'h99);
        rd(2'd3, r); chk("R9 flag kept", r, 0);
        sleep_req = 1'b0;
        idle(3);
        chk("R9 reacquire", sample_en, 1);

        // R7 reset mid-conversion keeps result
        wr(2'd2, 8'hC3);
        wr(2'd0, {2'd0, 3'd4, 3'b001});
        idle(3);
        wr(2'd0, {2'd0, 3'd4, 3'b101});
        wait_start(n);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd2, r); chk("R7 result kept", r, 8'hC3);
        rd(2'd0, r); chk("R7 ctrl cleared", r, 0);
        chk("R7 off", pwr_on, 0);
        chk("R7 switch open", sample_en, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule